// File: doc/BRIEF.md
# Power-Management Slave Command Channel

This block is a memory-mapped channel through which a host CPU issues one register read or one register write at a time to a power-management slave device. The host first loads a write-data register and then writes a command word. The command word carries an opcode, a direction flag, a slave identifier, a length code and a register address. Writing the command word launches a request on a generic downstream request/response port. A small state machine drives the transaction, and the host can read its encoding at any time from the status register.

A write finishes as soon as the downstream port responds, and the channel then returns to idle. A read stores the returned word in a read-data register. The channel then parks in a hold state and stays busy until the host acknowledges the data. A command written while the channel is busy is discarded, and it sets a sticky error flag. A separate register reports controller readiness from an input pin.

Top module: `pmic_cmd_chan`

## Requirements
- R1: After reset the status state field reads 0 (idle), the error flag is 0, the read-data register reads 0 and `dn_req` is low.
- R2: The register word offsets on `bus_addr` are fixed as follows: 0 is status, 1 is command, 2 is write data, 3 is read data, 4 is acknowledge and 5 is readiness. In the command word, bits 31:30 are the opcode, bit 29 is the write flag (1 = write), bits 28:24 are the slave ID, bits 23:16 are the length code (transfer bytes minus one, so 0 for a single byte) and the low ADDR_W bits are the register address. An accepted command presents these fields unchanged on `dn_opc`, `dn_we`, `dn_sid`, `dn_len` and `dn_addr`.
- R3: A write transaction carries on `dn_wdata` the write-data value that was loaded before the command was accepted.
- R4: After a command is accepted, the status state field (bits 2:0) reads 1 and `dn_req` stays high with stable fields until a cycle in which `dn_gnt` is high.
- R5: After the grant, the status state field reads 2 until `dn_rsp_vld` is high.
- R6: A write returns the state field to 0 on the response, with no acknowledge from the host.
- R7: A read stores `dn_rsp_data` in the read-data register on the response, and the state field becomes 3.
- R8: Writing the acknowledge register with bit 0 = 1 while the state field is 3 returns it to 0. An acknowledge with bit 0 = 0, or an acknowledge given in any other state, changes neither the state nor the read data.
- R9: A command write while the state field is not 0 launches no request and leaves the transaction in flight untouched. It sets status bit 8, and that bit stays set until reset.
- R10: The read-data register keeps its value until the next read completes; write completions do not alter it.
- R11: Bit 0 of the readiness register follows the `ctrl_ready` input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_ready | input | 1 | Controller readiness, shown in the readiness register |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word offset |
| bus_wdata | input | 32 | Register write data |
| bus_rdata | output | 32 | Register read data, combinational from `bus_addr` |
| dn_req | output | 1 | Downstream request, held until granted |
| dn_we | output | 1 | Downstream direction, 1 = write |
| dn_opc | output | 2 | Downstream opcode |
| dn_sid | output | 5 | Downstream slave ID |
| dn_len | output | 8 | Downstream length code |
| dn_addr | output | ADDR_W | Downstream register address |
| dn_wdata | output | 32 | Downstream write data |
| dn_gnt | input | 1 | Downstream accepts the request |
| dn_rsp_vld | input | 1 | Downstream response valid |
| dn_rsp_data | input | 32 | Downstream response data |

## Verification
The bench builds the channel with the default ADDR_W of 16. At that width the address field fills bits 15:0, and the all-ones and all-zeros addresses sit right against the length field. A bench responder inserts grant and response delays from zero up to several cycles. This keeps the channel in the request and wait states long enough to poll them. It also lets the bench issue rejected commands in each busy state and check the hold state against both acknowledge polarities.

// File: rtl/pmic_cmd_chan.sv
module pmic_cmd_chan #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_ready,
  input  logic              bus_wr,
  input  logic [2:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              dn_req,
  output logic              dn_we,
  output logic [1:0]        dn_opc,
  output logic [4:0]        dn_sid,
  output logic [7:0]        dn_len,
  output logic [ADDR_W-1:0] dn_addr,
  output logic [31:0]       dn_wdata,
  input  logic              dn_gnt,
  input  logic              dn_rsp_vld,
  input  logic [31:0]       dn_rsp_data
);

  localparam logic [2:0] OFS_STAT = 3'd0;
  localparam logic [2:0] OFS_CMD  = 3'd1;
  localparam logic [2:0] OFS_WDAT = 3'd2;
  localparam logic [2:0] OFS_RDAT = 3'd3;
  localparam logic [2:0] OFS_ACK  = 3'd4;
  localparam logic [2:0] OFS_RDY  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_REQ  = 3'd1,
    ST_WAIT = 3'd2,
    ST_HOLD = 3'd3
  } chan_st_t;

  chan_st_t    st;
  logic        err_q;
  logic [31:0] cmd_q, wdat_q, txw_q, rdat_q;

  wire cmd_wr  = bus_wr && (bus_addr == OFS_CMD);
  wire wdat_wr = bus_wr && (bus_addr == OFS_WDAT);
  wire ack_wr  = bus_wr && (bus_addr == OFS_ACK) && bus_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      err_q  <= 1'b0;
      cmd_q  <= '0;
      wdat_q <= '0;
      txw_q  <= '0;
      rdat_q <= '0;
    end else begin
      if (wdat_wr) wdat_q <= bus_wdata;
      if (cmd_wr && st != ST_IDLE) err_q <= 1'b1;
      unique case (st)
        ST_IDLE: if (cmd_wr) begin
          cmd_q <= bus_wdata;
          txw_q <= wdat_q;
          st    <= ST_REQ;
        end
        ST_REQ:  if (dn_gnt) st <= ST_WAIT;
        ST_WAIT: if (dn_rsp_vld) begin
          if (cmd_q[29]) st <= ST_IDLE;
          else begin
            rdat_q <= dn_rsp_data;
            st     <= ST_HOLD;
          end
        end
        ST_HOLD: if (ack_wr) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign dn_req   = (st == ST_REQ);
  assign dn_opc   = cmd_q[31:30];
  assign dn_we    = cmd_q[29];
  assign dn_sid   = cmd_q[28:24];
  assign dn_len   = cmd_q[23:16];
  assign dn_addr  = cmd_q[ADDR_W-1:0];
  assign dn_wdata = txw_q;

  always_comb begin
    case (bus_addr)
      OFS_STAT: bus_rdata = {23'd0, err_q, 5'd0, st};
      OFS_WDAT: bus_rdata = wdat_q;
      OFS_RDAT: bus_rdata = rdat_q;
      OFS_RDY:  bus_rdata = {31'd0, ctrl_ready};
      default:  bus_rdata = '0;
    endcase
  end

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req && !dn_gnt |=> dn_req && $stable(dn_addr) && $stable(dn_sid) && $stable(dn_we));

  // R9
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && !(bus_rdata == bus_rdata && st == ST_IDLE) |=> err_q && !dn_req || (st != ST_IDLE && err_q));

  // R9
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(err_q));

  // R8
  hold_park_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_HOLD && !ack_wr |=> st == ST_HOLD);

  // R10
  rdata_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(st == ST_WAIT && dn_rsp_vld && !dn_we) |=> $stable(rdat_q));

  // R6
  wr_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_WAIT && dn_rsp_vld && dn_we |=> st == ST_IDLE);

endmodule

// File: tb/pmic_cmd_chan_tb.sv
module pmic_cmd_chan_tb;
  logic        clk = 0, rst_n = 0, ctrl_ready = 0;
  logic        bus_wr = 0;
  logic [2:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        dn_req, dn_we, dn_gnt = 0, dn_rsp_vld = 0;
  logic [1:0]  dn_opc;
  logic [4:0]  dn_sid;
  logic [7:0]  dn_len;
  logic [15:0] dn_addr;
  logic [31:0] dn_wdata, dn_rsp_data = 0;

  pmic_cmd_chan #(.ADDR_W(16)) u_dut (.*);

  always #10 clk = ~clk;

  typedef struct packed {
    logic we; logic [1:0] opc; logic [4:0] sid; logic [7:0] len;
    logic [15:0] addr; logic [31:0] wdata; logic [31:0] rsp;
  } item_t;

  item_t exp_q[$];
  int checks = 0, errors = 0, gnt_dly = 0, rsp_dly = 0, seen = 0, pushed = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", r, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] v);
    bus_addr = a; #1 v = bus_rdata;
  endtask

  task automatic wait_st(logic [2:0] e, string r);
    logic [31:0] v;
    int n = 0;
    do begin
      @(negedge clk); rd(0, v); n++;
    end while (v[2:0] != e && n < 60);
    chk(r, {29'd0, v[2:0]}, {29'd0, e});
  endtask

  task automatic issue(item_t it);
    if (it.we) wr(2, it.wdata);
    exp_q.push_back(it); pushed++;
    wr(1, {it.opc, it.we, it.sid, it.len, it.addr});
  endtask

  // monitor / downstream responder
  initial begin
    forever begin
      @(negedge clk);
      if (dn_req) begin
        item_t e;
        seen++;
        if (exp_q.size() == 0) begin
          checks++; errors++;
          $display("FAIL R9: actual unexpected request expected none");
        end else begin
          e = exp_q.pop_front();
          chk("R2", {dn_opc, dn_we, dn_sid, dn_len, dn_addr}, {e.opc, e.we, e.sid, e.len, e.addr});
          if (e.we) chk("R3", dn_wdata, e.wdata);
          repeat (gnt_dly) @(negedge clk);
          chk("R4", {31'd0, dn_req}, 32'd1);
          dn_gnt = 1;
          @(negedge clk); dn_gnt = 0;
          repeat (rsp_dly) @(negedge clk);
          dn_rsp_vld = 1; dn_rsp_data = e.rsp;
          @(negedge clk); dn_rsp_vld = 0; dn_rsp_data = 0;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    item_t it;
    repeat (3) @(negedge clk);
    rd(0, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 rdata", v, 0);
    chk("R1 req", {31'd0, dn_req}, 0);
    rst_n = 1;
    @(negedge clk);
    rd(5, v); chk("R11 low", v, 0);
    ctrl_ready = 1; rd(5, v); chk("R11 high", v, 1);

    // write with delayed grant
    gnt_dly = 3; rsp_dly = 1;
    it = '{we:1, opc:2'd1, sid:5'd5, len:8'd0, addr:16'h1234, wdata:32'hCAFEF00D, rsp:0};
    issue(it);
    rd(0, v); chk("R4 status", {29'd0, v[2:0]}, 1);
    wait_st(2, "R5");
    wait_st(0, "R6");

    // read, then parked hold
    gnt_dly = 0; rsp_dly = 4;
    it = '{we:0, opc:2'd2, sid:5'd17, len:8'd0, addr:16'h00A0, wdata:0, rsp:32'hA5A55A5A};
    issue(it);
    wait_st(2, "R5 read");
    wr(1, 32'h2000_0001);
    rd(0, v); chk("R9 error in wait", {31'd0, v[8]}, 1);
    wait_st(3, "R7");
    rd(3, v); chk("R7 rdata", v, 32'hA5A55A5A);
    wr(4, 32'h0000_0000);
    rd(0, v); chk("R8 ack0", {29'd0, v[2:0]}, 3);
    wr(4, 32'h0000_0001);
    rd(0, v); chk("R8 ack1", {29'd0, v[2:0]}, 0);
    chk("R9 sticky", {31'd0, v[8]}, 1);

    // write does not disturb read data; stray ack ignored
    gnt_dly = 1; rsp_dly = 0;
    it = '{we:1, opc:2'd3, sid:5'd0, len:8'd3, addr:16'h0000, wdata:32'h0000_0001, rsp:32'hFFFF_FFFF};
    issue(it);
    wait_st(0, "R6 second");
    rd(3, v); chk("R10", v, 32'hA5A55A5A);
    wr(4, 32'h1);
    rd(0, v); chk("R8 idle ack", {29'd0, v[2:0]}, 0);
    rd(3, v); chk("R8 idle ack rdata", v, 32'hA5A55A5A);

    // boundary fields read, command rejected while request pending
    gnt_dly = 4; rsp_dly = 0;
    it = '{we:0, opc:2'd3, sid:5'd31, len:8'hFF, addr:16'hFFFF, wdata:0, rsp:32'h0};
    issue(it);
    wr(1, 32'h2100_0002);
    wait_st(3, "R7 boundary");
    rd(3, v); chk("R7 zero data", v, 0);
    wr(4, 32'h1);
    wait_st(0, "R8 final");
    repeat (5) @(negedge clk);
    chk("R9 requests", seen, pushed);
    chk("R9 queue", exp_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule